// File: doc/BRIEF.md
# Lane Parity Checker and Generator

This block handles parity for one side of a 36-bit word port, split into four 9-bit lanes. The most significant bit of each lane carries that lane's parity. On the inbound path it checks every lane against the parity rule chosen by a select input, odd or even. It drives an active-low error flag when any lane fails. On the outbound path it returns either the mailbox word or the queue word. When generation is enabled for the read, it replaces the top bit of each lane with freshly computed parity.

Each lane has one reduction tree, and checking and generation share it. While a generating mailbox read is set up, that tree is steered onto the mailbox word, so no check of the inbound bus can take place and the error flag is held inactive. A parameter picks the port flavour. In one flavour, generation is allowed only on mailbox reads. In the other, it is allowed on every read. That second flavour adds a dedicated tree per lane for queue words. The block is purely combinational and holds no storage.

Top module: `lane_parity_unit`

## Requirements
- R1: Lane k occupies bits 9k+8 down to 9k (k = 0..3), and bit 9k+8 is that lane's parity bit. Each lane is judged on its own.
- R2: `perr_n` is 0 when at least one lane fails its check and 1 when all four lanes pass, unless R5 applies.
- R3: With `odd_sel` = 1, a lane passes when its 9 bits hold an odd number of ones. With `odd_sel` = 0, it passes when they hold an even number.
- R4: On a generating read, each lane's bit 9k+8 of `rd_data` is set so that the 9-bit lane satisfies the rule chosen by `odd_sel`. Bits 9k+7..9k are copied unchanged from the selected source.
- R5: When `cs_n`=0, `en`=1, `wr`=0, `mbox_sel`=1 and `gen_en`=1, `perr_n` is 1 whatever `bus_in` carries.
- R6: With `MAIL_ONLY`=1, generation happens only on mailbox reads (`mbox_sel`=1). With `MAIL_ONLY`=0, it happens on any read with `gen_en`=1.
- R7: `rd_data` takes its source from `mbox_word` when `mbox_sel`=1 and from `fifo_word` when `mbox_sel`=0.
- R8: A read is `cs_n`=0, `en`=1, `wr`=0. Without a generating read, `rd_data` equals the selected source word exactly, and `perr_n` reflects only the lane checks.
- R9: `perr_n` and `rd_data` follow their inputs with no clock or register stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| odd_sel | input | 1 | Parity rule: 1 odd, 0 even |
| cs_n | input | 1 | Active-low port select |
| en | input | 1 | Access enable |
| wr | input | 1 | Direction: 1 write, 0 read |
| mbox_sel | input | 1 | Selects the mailbox word instead of the queue word |
| gen_en | input | 1 | Requests parity generation on reads |
| bus_in | input | 36 | Inbound word whose lanes are checked |
| fifo_word | input | 36 | Queue word offered for reads |
| mbox_word | input | 36 | Mailbox word offered for reads |
| rd_data | output | 36 | Outbound word, with regenerated parity when generating |
| perr_n | output | 1 | Active-low lane parity error flag |

## Verification
The bench builds the block with its default geometry of four 9-bit lanes in both flavours: `MAIL_ONLY`=1 as `u_dut` and `MAIL_ONLY`=0 as `u_dut_b`. Lanes of 9 bits make it cheap to sweep all 512 values of each lane under both parity rules while the other lanes hold known-good values. This covers every lane's check completely. All 32 combinations of the five access controls are also swept against several data patterns in both flavours. This reaches the masking corner, the flavour-dependent generation on queue reads, and the non-read pass-through.

// File: rtl/lpu_pkg.sv
package lpu_pkg;

  // Decoded access controls shared by the lanes.
  typedef struct packed {
    logic rd;    // a read access is set up
    logic gen;   // parity generation applies to this read
    logic mask;  // shared tree is taken by a generating mailbox read
  } lpu_ctl_t;

  // Fill bit that gives a lane the requested parity, from the XOR of its data bits.
  function automatic logic fill_bit(input logic data_xor, input logic odd);
    return data_xor ^ odd;
  endfunction

  // A lane passes when the XOR of all its bits equals the odd select.
  function automatic logic lane_fails(input logic data_xor, input logic par_bit,
                                      input logic odd);
    return (data_xor ^ par_bit) != odd;
  endfunction

endpackage

// File: rtl/lpu_ctrl.sv
module lpu_ctrl
  import lpu_pkg::*;
#(
  parameter bit MAIL_ONLY = 1'b1
) (
  input  logic     cs_n,
  input  logic     en,
  input  logic     wr,
  input  logic     mbox_sel,
  input  logic     gen_en,
  output lpu_ctl_t ctl
);

  logic rd_op;
  logic gen_op;
  logic mask_op;

  assign rd_op   = ~cs_n & en & ~wr;
  assign mask_op = rd_op & mbox_sel & gen_en;

  generate
    if (MAIL_ONLY) begin : g_mail_gen
      assign gen_op = mask_op;
    end else begin : g_any_gen
      assign gen_op = rd_op & gen_en;
    end
  endgenerate

  assign ctl = '{rd: rd_op, gen: gen_op, mask: mask_op};

  always_comb begin
    if (gen_op) AST_GEN_NEEDS_READ: assert (~cs_n && en && !wr); // R6
    if (mask_op) AST_MASK_IS_GEN: assert (gen_op);               // R5
  end

endmodule

// File: rtl/lpu_lane.sv
module lpu_lane
  import lpu_pkg::*;
#(
  parameter int unsigned LANE_W    = 9,
  parameter bit          MAIL_ONLY = 1'b1
) (
  input  logic              odd_sel,
  input  lpu_ctl_t          ctl,
  input  logic [LANE_W-1:0] bus_lane,
  input  logic [LANE_W-1:0] src_lane,
  output logic [LANE_W-1:0] out_lane,
  output logic              fail
);

  localparam int unsigned DW  = LANE_W - 1;
  localparam int unsigned MSB = LANE_W - 1;

  logic [DW-1:0] tree_in;
  logic          tree_x;
  logic          gen_bit;

  // One tree: steered onto the mailbox word while a generating mailbox read is set up.
  assign tree_in = ctl.mask ? src_lane[DW-1:0] : bus_lane[DW-1:0];
  assign tree_x  = ^tree_in;
  assign fail    = ~ctl.mask & lane_fails(tree_x, bus_lane[MSB], odd_sel);

  generate
    if (MAIL_ONLY) begin : g_shared_only
      assign gen_bit = fill_bit(tree_x, odd_sel);
    end else begin : g_with_queue_tree
      logic q_x;
      assign q_x     = ^src_lane[DW-1:0];
      assign gen_bit = ctl.mask ? fill_bit(tree_x, odd_sel) : fill_bit(q_x, odd_sel);
    end
  endgenerate

  assign out_lane = {(ctl.gen ? gen_bit : src_lane[MSB]), src_lane[DW-1:0]};

  always_comb begin
    if (ctl.gen) AST_LANE_GEN_PARITY: assert ((^out_lane) == odd_sel); // R4
    AST_LANE_DATA_KEPT: assert (out_lane[DW-1:0] == src_lane[DW-1:0]); // R4
    if (ctl.mask) AST_LANE_MASK_CLEAR: assert (!fail);                 // R5
    if (!ctl.gen) AST_LANE_PASSTHRU: assert (out_lane == src_lane);    // R8
  end

endmodule

// File: rtl/lane_parity_unit.sv
module lane_parity_unit
  import lpu_pkg::*;
#(
  parameter int unsigned LANES     = 4,
  parameter int unsigned LANE_W    = 9,
  parameter bit          MAIL_ONLY = 1'b1
) (
  input  logic                      odd_sel,
  input  logic                      cs_n,
  input  logic                      en,
  input  logic                      wr,
  input  logic                      mbox_sel,
  input  logic                      gen_en,
  input  logic [LANES*LANE_W-1:0]   bus_in,
  input  logic [LANES*LANE_W-1:0]   fifo_word,
  input  logic [LANES*LANE_W-1:0]   mbox_word,
  output logic [LANES*LANE_W-1:0]   rd_data,
  output logic                      perr_n
);

  localparam int unsigned W = LANES * LANE_W;

  lpu_ctl_t         ctl;
  logic [W-1:0]     src_word;
  logic [LANES-1:0] lane_fail;

  lpu_ctrl #(.MAIL_ONLY(MAIL_ONLY)) u_ctrl (
    .cs_n     (cs_n),
    .en       (en),
    .wr       (wr),
    .mbox_sel (mbox_sel),
    .gen_en   (gen_en),
    .ctl      (ctl)
  );

  assign src_word = mbox_sel ? mbox_word : fifo_word;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    lpu_lane #(.LANE_W(LANE_W), .MAIL_ONLY(MAIL_ONLY)) u_lane (
      .odd_sel  (odd_sel),
      .ctl      (ctl),
      .bus_lane (bus_in[k*LANE_W +: LANE_W]),
      .src_lane (src_word[k*LANE_W +: LANE_W]),
      .out_lane (rd_data[k*LANE_W +: LANE_W]),
      .fail     (lane_fail[k])
    );
  end

  assign perr_n = ~|lane_fail;

  always_comb begin
    if (!ctl.mask && ((^bus_in[LANE_W-1:0]) != odd_sel))
      AST_BAD_LANE0_FLAGS: assert (!perr_n);                        // R2
    if (ctl.mask) AST_MASK_FLAG_HIGH: assert (perr_n);              // R5
    if (!ctl.rd) AST_IDLE_SOURCE: assert (rd_data == src_word);     // R8
  end

endmodule

// File: tb/lane_parity_unit_tb.sv
module lane_parity_unit_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        odd_sel = 1'b0;
  logic        cs_n = 1'b1, en = 1'b0, wr = 1'b0, mbox_sel = 1'b0, gen_en = 1'b0;
  logic [35:0] bus_in = '0, fifo_word = '0, mbox_word = '0;
  logic [35:0] rd_a, rd_b;
  logic        perr_a, perr_b;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  lane_parity_unit #(.MAIL_ONLY(1'b1)) u_dut (
    .odd_sel(odd_sel), .cs_n(cs_n), .en(en), .wr(wr), .mbox_sel(mbox_sel),
    .gen_en(gen_en), .bus_in(bus_in), .fifo_word(fifo_word),
    .mbox_word(mbox_word), .rd_data(rd_a), .perr_n(perr_a));

  lane_parity_unit #(.MAIL_ONLY(1'b0)) u_dut_b (
    .odd_sel(odd_sel), .cs_n(cs_n), .en(en), .wr(wr), .mbox_sel(mbox_sel),
    .gen_en(gen_en), .bus_in(bus_in), .fifo_word(fifo_word),
    .mbox_word(mbox_word), .rd_data(rd_b), .perr_n(perr_b));

  task automatic check(input string req, input logic [35:0] act, input logic [35:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // A lane passes when its count of ones has the parity named by odd.
  function automatic bit lane_good(input logic [8:0] v, input bit odd);
    return ($countones(v) % 2) == (odd ? 1 : 0);
  endfunction

  function automatic bit exp_flag(input logic [35:0] b, input bit odd, input bit masked);
    bit all_ok = 1'b1;
    for (int k = 0; k < 4; k++) all_ok &= lane_good(b[9*k +: 9], odd);
    return masked ? 1'b1 : all_ok;
  endfunction

  function automatic logic [35:0] exp_rd(input logic [35:0] fw, input logic [35:0] mw,
                                         input bit mb, input bit do_gen, input bit odd);
    logic [35:0] w = mb ? mw : fw;
    if (do_gen)
      for (int k = 0; k < 4; k++)
        w[9*k+8] = (($countones(w[9*k +: 8]) % 2) == 0) ? odd : !odd;
    return w;
  endfunction

  initial begin
    #1_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // Idle state: all-zero bus passes even parity, data passes through.
    check("R2 idle flag", {35'b0, perr_a}, 36'd1);
    check("R8 idle data", rd_a, 36'd0);

    // R1 R2 R3: every value of every lane under both rules.
    for (int od = 0; od < 2; od++)
      for (int k = 0; k < 4; k++)
        for (int v = 0; v < 512; v++) begin
          logic [35:0] b;
          @(posedge clk);
          b = '0;
          for (int j = 0; j < 4; j++) b[9*j+8] = od[0];
          b[9*k +: 9] = v[8:0];
          odd_sel = od[0]; cs_n = 1'b1; bus_in = b;
          @(negedge clk);
          check("R1/R2/R3 lane check", {35'b0, perr_a},
                {35'b0, lane_good(v[8:0], od[0])});
        end

    // R4 R5 R6 R7 R8: all control combinations, both flavours.
    for (int od = 0; od < 2; od++)
      for (int c = 0; c < 32; c++)
        for (int p = 0; p < 6; p++) begin
          bit rd, ga, gb, msk;
          logic [35:0] fw, mw, b;
          fw = 36'h9_A5C3_1E07 ^ (36'h1_2345_6789 * p);
          mw = 36'h3_7F00_C0DE ^ (36'h0_9876_5431 * (p + 3));
          b  = fw ^ {mw[17:0], mw[35:18]};
          @(posedge clk);
          odd_sel = od[0];
          cs_n = c[0]; en = c[1]; wr = c[2]; mbox_sel = c[3]; gen_en = c[4];
          fifo_word = fw; mbox_word = mw; bus_in = b;
          rd  = !c[0] && c[1] && !c[2];
          msk = rd && c[3] && c[4];
          ga  = msk;                 // R6: generation on mailbox reads only
          gb  = rd && c[4];          // R6: generation on any read
          @(negedge clk);
          check("R4/R6/R7/R8 data A", rd_a, exp_rd(fw, mw, c[3], ga, od[0]));
          check("R4/R6/R7/R8 data B", rd_b, exp_rd(fw, mw, c[3], gb, od[0]));
          check("R2/R5 flag A", {35'b0, perr_a}, {35'b0, exp_flag(b, od[0], msk)});
          check("R2/R5 flag B", {35'b0, perr_b}, {35'b0, exp_flag(b, od[0], msk)});
        end

    // R5 with a bus that fails in every lane.
    @(posedge clk);
    odd_sel = 1'b1; cs_n = 1'b0; en = 1'b1; wr = 1'b0; mbox_sel = 1'b1; gen_en = 1'b1;
    bus_in = '0;
    @(negedge clk);
    check("R5 masked flag", {35'b0, perr_a}, 36'd1);

    // R9: no clock edge between input change and observation.
    @(negedge clk);
    cs_n = 1'b1; odd_sel = 1'b0; bus_in = 36'h0_0000_0001;
    #1 check("R9 comb fail", {35'b0, perr_a}, 36'd0);
    bus_in = 36'h0_0000_0003;
    #1 check("R9 comb pass", {35'b0, perr_a}, 36'd1);
    mbox_sel = 1'b1; mbox_word = 36'h5_5555_5555;
    #1 check("R9 comb data", rd_a, 36'h5_5555_5555);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule